// File: doc/BRIEF.md
# Signed-Digit Column Code Assembler

This block turns the comparator decisions of a two-stage cyclic column converter into a plain 12-bit unsigned sample code. In each conversion cycle, a pair of comparators reports one of three levels. The block reads that pair as a digit of value -1, 0 or +1. The first stage supplies the four heaviest digits of a pixel, and the first of those is decided while the stage samples. The second stage then supplies the eight lightest digits.

The two stages run as a pipeline. While the second stage is still resolving pixel N, the first stage is already producing digits for pixel N+1. For this reason the block keeps each stage's partial sum apart. When the first stage finishes a pixel, its partial sum moves into a hand-off register, and the second stage picks it up on that pixel's first second-stage digit. Each stage builds its sum by shift-and-add: on each digit the running value is doubled and the new digit is added. At the end the block adds a mid-scale offset and clamps the result to the code range.

Top module: `sdCodeConverter`

## Requirements
- R1: On a strobed digit the comparator pair {cmpHigh,cmpLow} is decoded as 2'b00 = -1, 2'b01 = 0, 2'b11 = +1.
- R2: The pair 2'b10 is illegal. It is counted as digit 0, and badDigit is high for exactly the one cycle after the edge that accepted it.
- R3: Digit order and weights are as follows. The four digits taken with stageSel=0 come first, and the digit taken with startConv=1 is d0. These are followed by eight digits taken with stageSel=1. The sum of d_i*2^(11-i) for i = 0..11, plus 2048, gives the code.
- R4: The code is clamped to the range 0..4095. A negative sum gives 0, and a sum above 4095 gives 4095.
- R5: codeValid is high for exactly one cycle, and that cycle follows the edge that accepted the twelfth digit. codeOut shows the new code in that same cycle and keeps its value until the next result.
- R6: Stage-one digits of the next pixel may be interleaved with stage-two digits of the current pixel. Doing so changes neither result.
- R7: A stage-one digit is ignored while stage one is idle and startConv is low. A startConv received partway through stage one starts a new pixel and discards the partial sum.
- R8: A stage-two digit is ignored while stage two is idle and no stage-one sum is waiting. Such a digit never produces codeValid.
- R9: While reset is held, and after it is released, codeOut is 0 and codeValid and badDigit are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| digitValid | input | 1 | A digit is presented this cycle |
| stageSel | input | 1 | 0 = digit from stage one, 1 = digit from stage two |
| startConv | input | 1 | With a stage-one digit: this is the first digit of a new pixel |
| cmpHigh | input | 1 | Upper comparator decision |
| cmpLow | input | 1 | Lower comparator decision |
| codeOut | output | 12 | Unsigned output code |
| codeValid | output | 1 | One-cycle strobe for a new codeOut |
| badDigit | output | 1 | Illegal comparator pair seen on the previous accepted digit |

## Verification
The bench drives full-scale runs of +1 and -1 digits, plus single heavy digits, so that both clamp limits are reached. A design that clamped wrongly, or not at all, would return wrapped codes near the opposite end of the range. A negative heaviest digit followed by eleven +1 digits lands exactly one code below mid-scale, which exposes an off-by-one in the offset or in the weights. The bench also interleaves the next pixel's stage-one digits with the current pixel's stage-two digits. If the hand-off were missing or reloaded at the wrong moment, the two pixels' codes would mix. Stray digits sent to an idle stage, and a restart mid-pixel, show up as shifted codes or as spurious strobes if the design accepted them.

// File: rtl/sdConvPkg.sv
package sdConvPkg;

  // Control strobes handed from the sequencer to the datapath
  typedef struct packed {
    logic s1Take;   // a stage-one digit is accepted
    logic s1First;  // it begins a new pixel
    logic s1Last;   // it completes stage one for the pixel
    logic s2Take;   // a stage-two digit is accepted
    logic s2First;  // it begins from the hand-off value
    logic s2Last;   // it completes the pixel
  } sdStrobe_t;

  // Comparator pair to signed digit; the illegal pair counts as zero
  function automatic logic signed [1:0] decodeDigit(input logic hi, input logic lo);
    case ({hi, lo})
      2'b11:   decodeDigit = 2'sd1;
      2'b00:   decodeDigit = -2'sd1;
      default: decodeDigit = 2'sd0;
    endcase
  endfunction

endpackage

// File: rtl/sdConvCtrl.sv
module sdConvCtrl
  import sdConvPkg::*;
#(
  parameter int S1_DIGITS = 4,
  parameter int S2_DIGITS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       digitValid,
  input  logic       stageSel,
  input  logic       startConv,
  output sdStrobe_t  strobe
);
  localparam int C1W = $clog2(S1_DIGITS + 1);
  localparam int C2W = $clog2(S2_DIGITS + 1);
  localparam logic [C1W-1:0] S1_LAST = C1W'(S1_DIGITS - 1);
  localparam logic [C2W-1:0] S2_LAST = C2W'(S2_DIGITS - 1);

  logic           s1Busy, s2Busy, hoValid;
  logic [C1W-1:0] s1Cnt, s1Idx;
  logic [C2W-1:0] s2Cnt, s2Idx;

  always_comb begin
    s1Idx          = startConv ? '0 : s1Cnt;
    strobe.s1Take  = digitValid && !stageSel && (startConv || s1Busy);
    strobe.s1First = strobe.s1Take && startConv;
    strobe.s1Last  = strobe.s1Take && (s1Idx == S1_LAST);
    s2Idx          = s2Busy ? s2Cnt : '0;
    strobe.s2Take  = digitValid && stageSel && (s2Busy || hoValid);
    strobe.s2First = strobe.s2Take && !s2Busy;
    strobe.s2Last  = strobe.s2Take && (s2Idx == S2_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Busy  <= 1'b0;
      s1Cnt   <= '0;
      s2Busy  <= 1'b0;
      s2Cnt   <= '0;
      hoValid <= 1'b0;
    end else begin
      if (strobe.s1Take) begin
        s1Busy <= !strobe.s1Last;
        s1Cnt  <= strobe.s1Last ? '0 : s1Idx + 1'b1;
      end
      if (strobe.s2Take) begin
        s2Busy <= !strobe.s2Last;
        s2Cnt  <= strobe.s2Last ? '0 : s2Idx + 1'b1;
      end
      if (strobe.s1Last)       hoValid <= 1'b1;
      else if (strobe.s2First) hoValid <= 1'b0;
    end
  end

endmodule

// File: rtl/sdConvData.sv
module sdConvData
  import sdConvPkg::*;
#(
  parameter int S1_DIGITS = 4,
  parameter int S2_DIGITS = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  sdStrobe_t                       strobe,
  input  logic                            cmpHigh,
  input  logic                            cmpLow,
  output logic [S1_DIGITS+S2_DIGITS-1:0]  codeOut,
  output logic                            codeValid,
  output logic                            badDigit
);
  localparam int CODE_W = S1_DIGITS + S2_DIGITS;
  localparam int ACC_W  = CODE_W + 2;
  localparam int HO_W   = S1_DIGITS + 2;
  localparam logic signed [ACC_W-1:0] OFFSET  = ACC_W'(1) << (CODE_W - 1);
  localparam logic signed [ACC_W-1:0] CODE_MX = (ACC_W'(1) << CODE_W) - ACC_W'(1);

  logic signed [1:0]       digit;
  logic signed [HO_W-1:0]  s1Acc, s1Next, hoReg, s1Base;
  logic signed [ACC_W-1:0] s2Acc, s2Next, s2Base, biased;
  logic [CODE_W-1:0]       satCode;

  always_comb begin
    digit   = decodeDigit(cmpHigh, cmpLow);
    s1Base  = strobe.s1First ? '0 : (s1Acc <<< 1);
    s1Next  = s1Base + {{(HO_W-2){digit[1]}}, digit};
    s2Base  = strobe.s2First ? {{(ACC_W-HO_W){hoReg[HO_W-1]}}, hoReg} : s2Acc;
    s2Next  = (s2Base <<< 1) + {{(ACC_W-2){digit[1]}}, digit};
    biased  = s2Next + OFFSET;
    if (biased < 0)            satCode = '0;
    else if (biased > CODE_MX) satCode = '1;
    else                       satCode = biased[CODE_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Acc     <= '0;
      hoReg     <= '0;
      s2Acc     <= '0;
      codeOut   <= '0;
      codeValid <= 1'b0;
      badDigit  <= 1'b0;
    end else begin
      if (strobe.s1Take) s1Acc <= s1Next;
      if (strobe.s1Last) hoReg <= s1Next;
      if (strobe.s2Take) s2Acc <= s2Next;
      if (strobe.s2Last) codeOut <= satCode;
      codeValid <= strobe.s2Last;
      badDigit  <= (strobe.s1Take || strobe.s2Take) && cmpHigh && !cmpLow;
    end
  end

endmodule

// File: rtl/sdCodeConverter.sv
module sdCodeConverter
  import sdConvPkg::*;
#(
  parameter int S1_DIGITS = 4,
  parameter int S2_DIGITS = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           digitValid,
  input  logic                           stageSel,
  input  logic                           startConv,
  input  logic                           cmpHigh,
  input  logic                           cmpLow,
  output logic [S1_DIGITS+S2_DIGITS-1:0] codeOut,
  output logic                           codeValid,
  output logic                           badDigit
);
  sdStrobe_t strobe;

  sdConvCtrl #(.S1_DIGITS(S1_DIGITS), .S2_DIGITS(S2_DIGITS)) ctrl_i (
    .clk(clk), .rstN(rstN), .digitValid(digitValid), .stageSel(stageSel),
    .startConv(startConv), .strobe(strobe)
  );

  sdConvData #(.S1_DIGITS(S1_DIGITS), .S2_DIGITS(S2_DIGITS)) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmpHigh(cmpHigh), .cmpLow(cmpLow),
    .codeOut(codeOut), .codeValid(codeValid), .badDigit(badDigit)
  );

endmodule

// File: rtl/sdConvChecker.sv
module sdConvChecker #(
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              digitValid,
  input logic              stageSel,
  input logic              cmpHigh,
  input logic              cmpLow,
  input logic [CODE_W-1:0] codeOut,
  input logic              codeValid,
  input logic              badDigit
);
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    codeValid |=> !codeValid); // R5
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !codeValid |-> $stable(codeOut)); // R5
  AST_VALID_NEEDS_DIGIT: assert property (@(posedge clk) disable iff (!rstN)
    codeValid |-> $past(digitValid && stageSel)); // R8
  AST_BAD_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    badDigit |-> $past(digitValid && cmpHigh && !cmpLow)); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !digitValid |=> !codeValid); // R5
endmodule

bind sdCodeConverter sdConvChecker #(.CODE_W(S1_DIGITS + S2_DIGITS)) chk_i (
  .clk(clk), .rstN(rstN), .digitValid(digitValid), .stageSel(stageSel),
  .cmpHigh(cmpHigh), .cmpLow(cmpLow), .codeOut(codeOut),
  .codeValid(codeValid), .badDigit(badDigit)
);

// File: tb/sdCodeConverter_tb_top.sv
module sdCodeConverter_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic digitValid = 1'b0, stageSel = 1'b0, startConv = 1'b0;
  logic cmpHigh = 1'b0, cmpLow = 1'b0;
  logic [11:0] codeOut;
  logic codeValid, badDigit;
  int nChecks = 0, nFails = 0;

  always #4 clk = ~clk;

  sdCodeConverter dut_i (
    .clk(clk), .rstN(rstN), .digitValid(digitValid), .stageSel(stageSel),
    .startConv(startConv), .cmpHigh(cmpHigh), .cmpLow(cmpLow),
    .codeOut(codeOut), .codeValid(codeValid), .badDigit(badDigit)
  );

  // pairs {hi,lo}: 00=-1, 01=0, 11=+1, 10=illegal; d0 in bits [23:22]
  localparam int NV = 12;
  localparam logic [35:0] VEC [NV] = '{
    {24'b01_01_01_01_01_01_01_01_01_01_01_01, 12'd2048},
    {24'b11_11_11_11_11_11_11_11_11_11_11_11, 12'd4095},
    {24'b00_00_00_00_00_00_00_00_00_00_00_00, 12'd0},
    {24'b11_01_01_01_01_01_01_01_01_01_01_01, 12'd4095},
    {24'b00_01_01_01_01_01_01_01_01_01_01_01, 12'd0},
    {24'b11_00_01_01_01_01_01_01_01_01_01_01, 12'd3072},
    {24'b01_01_01_01_01_01_01_01_01_01_01_11, 12'd2049},
    {24'b01_01_01_01_01_01_01_01_01_01_01_00, 12'd2047},
    {24'b00_11_11_11_11_11_11_11_11_11_11_11, 12'd2047},
    {24'b01_01_01_00_11_01_01_01_01_01_01_01, 12'd1920},
    {24'b10_10_10_10_10_10_10_10_10_10_10_10, 12'd2048},
    {24'b01_01_11_01_01_01_01_01_01_01_01_01, 12'd2560}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendDigit(input logic s, input logic st, input logic h, input logic l);
    @(negedge clk);
    stageSel = s; startConv = st; cmpHigh = h; cmpLow = l; digitValid = 1'b1;
  endtask

  task automatic idle();
    @(negedge clk);
    digitValid = 1'b0; startConv = 1'b0;
  endtask

  task automatic sendStage1(input logic [23:0] p);
    for (int i = 0; i < 4; i++) sendDigit(1'b0, i == 0, p[23-2*i], p[22-2*i]);
  endtask

  task automatic sendStage2(input logic [23:0] p);
    for (int i = 0; i < 8; i++) sendDigit(1'b1, 1'b0, p[15-2*i], p[14-2*i]);
  endtask

  // Model of R1/R3/R4: digit weights, offset and clamp
  function automatic int expCode(input logic [23:0] p);
    int sum = 0;
    for (int i = 0; i < 12; i++) begin
      logic [1:0] pr = p[23-2*i -: 2];
      sum = sum * 2 + ((pr == 2'b11) ? 1 : (pr == 2'b00) ? -1 : 0);
    end
    sum += 2048;
    if (sum < 0) sum = 0;
    if (sum > 4095) sum = 4095;
    return sum;
  endfunction

  // Ideal cyclic converter with three-level decisions, full scale = 65536
  function automatic logic [23:0] adcDigits(input int vin);
    logic [23:0] p = '0;
    int r = vin;
    for (int i = 0; i < 12; i++) begin
      int d = (r > 16384) ? 1 : (r < -16384) ? -1 : 0;
      p[23-2*i -: 2] = (d == 1) ? 2'b11 : (d == -1) ? 2'b00 : 2'b01;
      r = 2 * r - d * 65536;
    end
    return p;
  endfunction

  task automatic checkPixel(input logic [23:0] p, input int exp, input string req);
    sendStage1(p);
    sendStage2(p);
    idle();
    chk(codeValid === 1'b1, req, codeValid, 1);
    chk(codeOut === 12'(exp), req, codeOut, exp);
  endtask

  initial begin
    #2000000;
    nFails++; nChecks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(codeOut === 12'd0 && codeValid === 1'b0 && badDigit === 1'b0, "R9 in reset", codeOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(codeOut === 12'd0 && codeValid === 1'b0 && badDigit === 1'b0, "R9 after reset", codeOut, 0);

    // Table walk: R1 R3 R4
    for (int v = 0; v < NV; v++) begin
      checkPixel(VEC[v][35:12], int'(VEC[v][11:0]), "R3/R4 vector");
      chk(expCode(VEC[v][35:12]) == int'(VEC[v][11:0]), "R1 model", expCode(VEC[v][35:12]), VEC[v][11:0]);
    end

    // R5: strobe lasts one cycle, code holds
    checkPixel(VEC[5][35:12], 3072, "R5 setup");
    idle();
    chk(codeValid === 1'b0, "R5 pulse width", codeValid, 0);
    chk(codeOut === 12'd3072, "R5 hold", codeOut, 3072);

    // R2: illegal pair flagged for one cycle
    sendDigit(1'b0, 1'b1, 1'b1, 1'b0);
    idle();
    chk(badDigit === 1'b1, "R2 flag", badDigit, 1);
    idle();
    chk(badDigit === 1'b0, "R2 flag clears", badDigit, 0);
    for (int i = 1; i < 4; i++) sendDigit(1'b0, 1'b0, 1'b0, 1'b1);
    sendStage2(24'h555555);
    idle();
    chk(codeOut === 12'd2048, "R2 illegal as zero", codeOut, 2048);

    // R6: interleaved pipeline, A=3072 then B=1920
    sendStage1(VEC[5][35:12]);
    for (int k = 0; k < 8; k++) begin
      sendDigit(1'b1, 1'b0, VEC[5][35-2*(k+4)], VEC[5][34-2*(k+4)]);
      if (k < 4) sendDigit(1'b0, k == 0, VEC[9][35-2*k], VEC[9][34-2*k]);
    end
    idle();
    chk(codeValid === 1'b1 && codeOut === 12'd3072, "R6 first pixel", codeOut, 3072);
    sendStage2(VEC[9][35:12]);
    idle();
    chk(codeValid === 1'b1 && codeOut === 12'd1920, "R6 second pixel", codeOut, 1920);

    // R7: stray stage-one digit while idle, then restart mid-pixel
    sendDigit(1'b0, 1'b0, 1'b1, 1'b1);
    sendDigit(1'b0, 1'b1, 1'b1, 1'b1);
    sendDigit(1'b0, 1'b0, 1'b1, 1'b1);
    checkPixel(24'h555555, 2048, "R7 restart and stray ignored");

    // R8: stage-two digits with nothing handed off
    begin
      int seen = 0;
      for (int i = 0; i < 10; i++) begin
        sendDigit(1'b1, 1'b0, 1'b1, 1'b1);
        if (codeValid) seen++;
      end
      idle();
      if (codeValid) seen++;
      chk(seen == 0, "R8 no strobe", seen, 0);
    end
    checkPixel(24'h555555, 2048, "R8 ignored digits");

    // Random inputs through the ideal converter model (R3/R4)
    for (int n = 0; n < 40; n++) begin
      int vin = int'($urandom_range(0, 140000)) - 70000;
      logic [23:0] p = adcDigits(vin);
      checkPixel(p, expCode(p), "R3 random");
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule